// File: doc/BRIEF.md
# Serial Flash Read Command Responder

This block is the device-side read engine of a serial NOR flash. A host selects it by pulling chip select low, shifts in an 8-bit command and a 3- or 4-byte start address on the serial input, and then clocks out as many data bytes as it wants. Two read flavours are answered: a single-line fast read, where one bit leaves per serial clock, and a dual-line read, where two bits leave per serial clock on a pair of pins. Whether the command takes 3 or 4 address bytes depends on the opcode and, for two of the opcodes, on an extended-addressing configuration bit.

A latency configuration bit chooses whether the data follows the address at once or after a fixed run of dummy clocks. The data comes from a small internal byte array that a preload port fills. The read pointer steps by one byte after each byte and wraps at the top of the array, so one command can stream without end. The block runs on a system clock. It oversamples the serial clock and chip select, which are expected to be synchronous to that clock, and it must see every serial-clock level for at least two system-clock cycles.

Top module: `flash_read_responder`

## Requirements
- R1: Command byte 0x0B starts a single-line read. It takes 3 address bytes while the extended-addressing bit is 0 and 4 address bytes while it is 1.
- R2: Command byte 0x0C starts a single-line read that always takes 4 address bytes, whatever the extended-addressing bit holds.
- R3: Command byte 0x3B starts a dual-line read, with 3 or 4 address bytes chosen as in R1. Command byte 0x3C starts a dual-line read that always takes 4 address bytes. In the dual-line read, each serial clock carries two bits MSB first: the higher bit of the pair is on `io1Out` and the lower bit is on `io0Out`, and both enables are high.
- R4: When the latency bit is 1, exactly `DUMMY_CYCLES` (default 8) serial clocks follow the last address bit before data starts. The outputs stay disabled during those clocks, and the serial input is ignored. When the latency bit is 0, data follows the last address bit directly.
- R5: Command and address bits are sampled MSB first on rising serial-clock edges. In the single-line read, data leaves MSB first on `io1Out` only, one bit per serial clock. The output changes only after a falling edge of the serial clock and holds across the rising edge, and the first data bit is valid after the falling edge of the last address or dummy clock.
- R6: After each complete byte, the read address steps to the next byte, for as long as chip select stays low.
- R7: The array holds `DEPTH` bytes (a power of two). Address bits above the array size are ignored, and the read after address `DEPTH-1` continues at address 0.
- R8: Driving `csN` high aborts any command at once, even in the same cycle as a serial-clock edge. Both output enables go low, and the next selection starts a fresh command.
- R9: Any other command byte is ignored. The outputs stay disabled and all further serial clocks are discarded until `csN` goes high.
- R10: The output enables are low whenever no data is being driven. In the single-line read, `io0Oe` stays low.
- R11: After reset, both enables are low, the extended-addressing bit is 0 and the latency bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host, idle low |
| csN | input | 1 | Active-low chip select |
| serIn | input | 1 | Serial command/address input (shared IO0 line, input side) |
| cfgWrEn | input | 1 | Writes the two configuration bits |
| cfgExtIn | input | 1 | Extended-addressing bit to write |
| cfgLatIn | input | 1 | Latency bit to write (1 = dummy clocks) |
| loadEn | input | 1 | Preload write strobe for the array |
| loadAddr | input | $clog2(DEPTH) | Preload byte address |
| loadData | input | 8 | Preload byte value |
| io1Out | output | 1 | Data line 1 (single-line data / high bit of dual pair) |
| io1Oe | output | 1 | Output enable for line 1 |
| io0Out | output | 1 | Data line 0 (low bit of dual pair) |
| io0Oe | output | 1 | Output enable for line 0 |

## Verification
Deselection and a serial-clock falling edge can reach the block in the same system-clock cycle. In that cycle, either the abort or the data shifter could win. The bench lowers the serial clock and raises chip select on the same system-clock edge in the middle of a byte. It then requires both enables to be low and a following command to return the correct bytes from its own address, with no bit position carried over from the aborted stream. A second overlap is a byte boundary landing on the top array address: the load of the last byte and the pointer wrap happen together, and the bench checks that the byte after it is the one at address 0.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_FAST      = 8'h0B;
  localparam logic [BYTE_W-1:0] OPC_FAST_WIDE = 8'h0C;
  localparam logic [BYTE_W-1:0] OPC_DUAL      = 8'h3B;
  localparam logic [BYTE_W-1:0] OPC_DUAL_WIDE = 8'h3C;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;  // shift one address bit in
    logic loadByte;   // fetch byte, drive its first bit(s), advance pointer
    logic shiftBits;  // drive the next bit(s) of the held byte
    logic outClear;   // deselect: drop the enables
    logic dualMode;   // two bits per serial clock
  } rdStrobe_t;

endpackage

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int DUMMY_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sck,
  input  logic      csN,
  input  logic      serIn,
  input  logic      cfgWrEn,
  input  logic      cfgExtIn,
  input  logic      cfgLatIn,
  output rdStrobe_t strb
);

  localparam int CNT_W = $clog2((DUMMY_CYCLES > 32) ? DUMMY_CYCLES : 32) + 1;
  localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_A24  = CNT_W'(23);
  localparam logic [CNT_W-1:0] LAST_A32  = CNT_W'(31);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CYCLES - 1);

  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] addrLast;
  logic [BYTE_W-2:0] opSr;
  logic [2:0]       bitPos;
  logic             dualReg;
  logic             sckPrev;
  logic             cfgExt;
  logic             cfgLat;
  logic             sckRise;
  logic             sckFall;
  logic [BYTE_W-1:0] opByte;

  assign sckRise = sck & ~sckPrev & ~csN;
  assign sckFall = ~sck & sckPrev & ~csN;
  assign opByte  = {opSr, serIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgExt <= 1'b0;
      cfgLat <= 1'b0;
    end else if (cfgWrEn) begin
      cfgExt <= cfgExtIn;
      cfgLat <= cfgLatIn;
    end
  end

  always_comb begin
    strb           = '0;
    strb.dualMode  = dualReg;
    strb.outClear  = csN;
    strb.addrShift = (state == ST_ADDR) && sckRise;
    strb.loadByte  = (state == ST_DATA) && sckFall && (bitPos == 3'd0);
    strb.shiftBits = (state == ST_DATA) && sckFall && (bitPos != 3'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      cnt      <= '0;
      addrLast <= LAST_A24;
      opSr     <= '0;
      bitPos   <= '0;
      dualReg  <= 1'b0;
    end else if (csN) begin
      state  <= ST_CMD;
      cnt    <= '0;
      bitPos <= '0;
    end else begin
      unique case (state)
        ST_CMD: if (sckRise) begin
          opSr <= opByte[BYTE_W-2:0];
          cnt  <= cnt + 1'b1;
          if (cnt == LAST_OP) begin
            cnt   <= '0;
            state <= ST_ADDR;
            unique case (opByte)
              OPC_FAST: begin
                dualReg  <= 1'b0;
                addrLast <= cfgExt ? LAST_A32 : LAST_A24;
              end
              OPC_FAST_WIDE: begin
                dualReg  <= 1'b0;
                addrLast <= LAST_A32;
              end
              OPC_DUAL: begin
                dualReg  <= 1'b1;
                addrLast <= cfgExt ? LAST_A32 : LAST_A24;
              end
              OPC_DUAL_WIDE: begin
                dualReg  <= 1'b1;
                addrLast <= LAST_A32;
              end
              default: state <= ST_IGNORE;
            endcase
          end
        end
        ST_ADDR: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == addrLast) begin
            cnt    <= '0;
            bitPos <= '0;
            state  <= cfgLat ? ST_DUMMY : ST_DATA;
          end
        end
        ST_DUMMY: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_DUMMY) begin
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: if (sckFall) begin
          bitPos <= (dualReg && bitPos == 3'd3) ? 3'd0 : bitPos + 3'd1;
        end
        default: ;
      endcase
    end
  end

  // an unknown opcode keeps the block deaf while selected
  assert_ignore_sticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !csN) |=> (state == ST_IGNORE));

  // entering data straight from the address needs a zero latency setting
  assert_no_skip_dummy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_ADDR) |-> !$past(cfgLat));

  // the shift phase never outruns the byte
  assert_bitpos_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    dualReg |-> (bitPos <= 3'd3));

endmodule

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rdStrobe_t                strb,
  input  logic                     serIn,
  input  logic                     loadEn,
  input  logic [$clog2(DEPTH)-1:0] loadAddr,
  input  logic [BYTE_W-1:0]        loadData,
  output logic                     io1Out,
  output logic                     io1Oe,
  output logic                     io0Out,
  output logic                     io0Oe
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0] outSr;
  logic [BYTE_W-1:0] byteNow;

  assign byteNow = mem[addrReg];

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  // only the low address bits survive the shift, so upper bits drop out
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.addrShift) begin
      addrReg <= {addrReg[ADDR_W-2:0], serIn};
    end else if (strb.loadByte) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr  <= '0;
      io1Out <= 1'b0;
      io0Out <= 1'b0;
    end else if (strb.loadByte) begin
      io1Out <= byteNow[BYTE_W-1];
      if (strb.dualMode) begin
        io0Out <= byteNow[BYTE_W-2];
        outSr  <= {byteNow[BYTE_W-3:0], 2'b00};
      end else begin
        outSr  <= {byteNow[BYTE_W-2:0], 1'b0};
      end
    end else if (strb.shiftBits) begin
      io1Out <= outSr[BYTE_W-1];
      if (strb.dualMode) begin
        io0Out <= outSr[BYTE_W-2];
        outSr  <= {outSr[BYTE_W-3:0], 2'b00};
      end else begin
        outSr  <= {outSr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      io1Oe <= 1'b0;
      io0Oe <= 1'b0;
    end else if (strb.outClear) begin
      io1Oe <= 1'b0;
      io0Oe <= 1'b0;
    end else if (strb.loadByte) begin
      io1Oe <= 1'b1;
      io0Oe <= strb.dualMode;
    end
  end

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadByte && addrReg == TOP_ADDR) |=> (addrReg == '0));

  assert_moves_after_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({io1Out, io0Out}) |-> $past(strb.loadByte || strb.shiftBits));

  assert_step_per_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftBits |=> $stable(addrReg));

endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import flash_rd_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int DUMMY_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sck,
  input  logic                     csN,
  input  logic                     serIn,
  input  logic                     cfgWrEn,
  input  logic                     cfgExtIn,
  input  logic                     cfgLatIn,
  input  logic                     loadEn,
  input  logic [$clog2(DEPTH)-1:0] loadAddr,
  input  logic [7:0]               loadData,
  output logic                     io1Out,
  output logic                     io1Oe,
  output logic                     io0Out,
  output logic                     io0Oe
);

  rdStrobe_t strb;

  flash_rd_ctrl #(.DUMMY_CYCLES(DUMMY_CYCLES)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sck      (sck),
    .csN      (csN),
    .serIn    (serIn),
    .cfgWrEn  (cfgWrEn),
    .cfgExtIn (cfgExtIn),
    .cfgLatIn (cfgLatIn),
    .strb     (strb)
  );

  flash_rd_datapath #(.DEPTH(DEPTH)) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .serIn    (serIn),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .io1Out   (io1Out),
    .io1Oe    (io1Oe),
    .io0Out   (io0Out),
    .io0Oe    (io0Oe)
  );

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!io1Oe && !io0Oe));

  assert_low_line_only_dual_R10: assert property (@(posedge clk) disable iff (!rstN)
    io0Oe |-> io1Oe);

endmodule

// File: tb/flash_read_responder_test.sv
`timescale 1ns/1ps
module flash_read_responder_test;

  localparam int DEPTH = 256;
  localparam int HALF  = 3;
  localparam int DUMMY = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       csN = 1'b1;
  logic       serIn = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic       cfgExtIn = 1'b0;
  logic       cfgLatIn = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic       io1Out, io1Oe, io0Out, io0Oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_read_responder #(.DEPTH(DEPTH), .DUMMY_CYCLES(DUMMY)) uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .serIn(serIn),
    .cfgWrEn(cfgWrEn), .cfgExtIn(cfgExtIn), .cfgLatIn(cfgLatIn),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .io1Out(io1Out), .io1Oe(io1Oe), .io0Out(io0Out), .io0Oe(io0Oe)
  );

  function automatic logic [7:0] pat(input longint a);
    return 8'(((a % DEPTH) * 37 + 11));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic bitVal);
    @(negedge clk);
    serIn = bitVal;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i]);
  endtask

  task automatic select();
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk);
    csN = 1'b1;
    sck = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input logic ext, input logic lat);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgExtIn = ext; cfgLatIn = lat;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic startCmd(input logic [7:0] op, input logic [31:0] addr, input int nAddr);
    select();
    sendByte(op);
    for (int k = nAddr - 1; k >= 0; k--) sendByte(addr[8*k +: 8]);
  endtask

  // sample before each rising edge; the trailing pulse exposes the next byte
  task automatic rxByte(input bit dual, input logic [7:0] exp, input string req);
    logic [7:0] got;
    bit oeOk;
    oeOk = 1'b1;
    if (dual) begin
      for (int i = 3; i >= 0; i--) begin
        got[2*i+1] = io1Out;
        got[2*i]   = io0Out;
        if (!(io1Oe && io0Oe)) oeOk = 1'b0;
        pulse(1'b0);
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        got[i] = io1Out;
        if (!(io1Oe && !io0Oe)) oeOk = 1'b0;
        pulse(1'b0);
      end
    end
    check(got == exp, req, got, exp);
    check(oeOk, {req, " enables R10"}, {io1Oe, io0Oe}, dual ? 2'b11 : 2'b10);
  endtask

  task automatic t_reset();
    check(!io1Oe && !io0Oe, "R11 reset enables", {io1Oe, io0Oe}, 0);
    startCmd(8'h0B, 32'h0000_0000, 3);
    rxByte(0, pat(0), "R11 default 3-byte no latency");
    deselect();
    check(!io1Oe && !io0Oe, "R8 deselect enables", {io1Oe, io0Oe}, 0);
  endtask

  task automatic t_fast3();
    logic held;
    setCfg(0, 0);
    startCmd(8'h0B, 32'h0000_0010, 3);
    held = io1Out;
    @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    check(io1Out == held, "R5 holds across rising edge", io1Out, held);
    sck = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    for (int i = 6; i >= 0; i--) pulse(1'b0);
    rxByte(0, pat(8'h11), "R1 R6 second byte");
    rxByte(0, pat(8'h12), "R6 third byte");
    deselect();
  endtask

  task automatic t_fast4ext();
    setCfg(1, 0);
    startCmd(8'h0B, 32'h1234_5620, 4);
    rxByte(0, pat(8'h20), "R1 4-byte with ext bit, R7 upper bits ignored");
    rxByte(0, pat(8'h21), "R6 after 4-byte address");
    deselect();
  endtask

  task automatic t_fast4op();
    setCfg(0, 0);
    startCmd(8'h0C, 32'hFFFF_FF40, 4);
    rxByte(0, pat(8'h40), "R2 wide opcode ignores ext bit");
    deselect();
  endtask

  task automatic t_dummy();
    bit quiet;
    setCfg(0, 1);
    startCmd(8'h0B, 32'h0000_0055, 3);
    quiet = 1'b1;
    for (int d = 0; d < DUMMY; d++) begin
      if (io1Oe || io0Oe) quiet = 1'b0;
      pulse(d[0]);
    end
    check(quiet, "R4 disabled during dummy clocks", 0, 0);
    rxByte(0, pat(8'h55), "R4 first byte after dummy clocks");
    deselect();
  endtask

  task automatic t_dual();
    setCfg(0, 0);
    startCmd(8'h3B, 32'h0000_0080, 3);
    rxByte(1, pat(8'h80), "R3 dual 3-byte");
    rxByte(1, pat(8'h81), "R3 R6 dual next byte");
    deselect();
    setCfg(1, 0);
    startCmd(8'h3B, 32'hAB00_00C4, 4);
    rxByte(1, pat(8'hC4), "R3 dual with ext bit");
    deselect();
  endtask

  task automatic t_dual4lat();
    setCfg(0, 1);
    startCmd(8'h3C, 32'h0000_0033, 4);
    for (int d = 0; d < DUMMY; d++) pulse(1'b1);
    rxByte(1, pat(8'h33), "R3 R4 wide dual with dummy clocks");
    deselect();
    setCfg(0, 0);
  endtask

  task automatic t_wrap();
    startCmd(8'h0B, 32'h0000_00FE, 3);
    rxByte(0, pat(8'hFE), "R7 byte FE");
    rxByte(0, pat(8'hFF), "R7 top byte");
    rxByte(0, pat(8'h00), "R7 wrapped to zero");
    rxByte(0, pat(8'h01), "R7 continues after wrap");
    deselect();
  endtask

  task automatic t_badop();
    bit quiet;
    startCmd(8'h03, 32'h0000_0000, 3);
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (io1Oe || io0Oe) quiet = 1'b0;
      pulse(k[1]);
    end
    check(quiet, "R9 unknown opcode keeps outputs off", 0, 0);
    // a valid opcode byte while ignoring must also be discarded
    sendByte(8'h0B);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h10);
    check(!io1Oe && !io0Oe, "R9 later opcode discarded", {io1Oe, io0Oe}, 0);
    deselect();
    startCmd(8'h0B, 32'h0000_0077, 3);
    rxByte(0, pat(8'h77), "R9 recovered after deselect");
    deselect();
  endtask

  task automatic t_abort();
    startCmd(8'h3B, 32'h0000_0030, 3);
    rxByte(1, pat(8'h30), "R8 before abort");
    pulse(1'b0);
    @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    csN = 1'b1;
    repeat (2) @(negedge clk);
    check(!io1Oe && !io0Oe, "R8 abort on same cycle as falling edge", {io1Oe, io0Oe}, 0);
    repeat (2) @(negedge clk);
    startCmd(8'h0B, 32'h0000_0040, 3);
    rxByte(0, pat(8'h40), "R8 fresh command after abort");
    deselect();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      loadEn = 1'b1;
      loadAddr = 8'(a);
      loadData = pat(a);
    end
    @(negedge clk);
    loadEn = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fast3();
    t_fast4ext();
    t_fast4op();
    t_dummy();
    t_dual();
    t_dual4lat();
    t_wrap();
    t_badop();
    t_abort();
    done = 1;
    report();
  end

endmodule